// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives a stereo serial audio stream as a slave. The bit clock, word select and data lines come from an external source. The block oversamples them in a faster system clock domain and treats each rising edge of the bit clock as one bit slot. Left and right words share the data line and are told apart by the level of word select.

The framing is chosen in one of two ways. In register mode a 3-bit code selects the framing. In pin mode a 2-bit code selects it and the 3-bit code is ignored. The supported framings are:
- I2S, where the MSB follows one slot after the word-select change.
- MSB-justified, where the MSB arrives in the slot of the change itself.
- LSB-justified at 16, 18 or 20 bits, where the word ends in the last slot before the next change.

An LSB-justified word is found by keeping the most recent bits in a history register and reading them out when the next word-select change arrives. When a right word completes, the block presents the left and right samples of that frame as a registered 20-bit pair, together with a one-cycle valid pulse.

Top module: `serial_audio_rx`

## Requirements
- R1: With `pin_mode` low, `fmt_sel` selects the framing: 3'b000 I2S, 3'b001 LSB-justified 16 bit, 3'b010 LSB-justified 18 bit, 3'b011 LSB-justified 20 bit, 3'b100 MSB-justified.
- R2: With `pin_mode` high, `pin_fmt` selects the framing: 2'b00 I2S, 2'b01 LSB-justified 16, 2'b10 LSB-justified 18, 2'b11 LSB-justified 20. In this mode `fmt_sel` has no effect.
- R3: Data and word select are taken at each rising edge of `bclk_in`, and words arrive MSB first. Word select low carries the left word and word select high carries the right word.
- R4: In I2S the MSB is in the second slot after a word-select change. In MSB-justified framing the MSB is in the first slot. Bits past the 20th slot of the word are ignored, and a shorter word leaves zeros in the low bits.
- R5: In LSB-justified framing of N bits, the word is the last N slots before the next word-select change. It is sign-extended from bit N-1 to 20 bits.
- R6: After a right word completes, `valid_out` is high for exactly one cycle and `left_out`/`right_out` hold the left and right words of that frame. At all other times the outputs keep their values.
- R7: In LSB-justified framing, a word-select half that holds fewer slots than N pulses `err_out` for one cycle. That frame is not output. A half of exactly N slots is accepted.
- R8: The unused codes 3'b101 to 3'b111 produce neither `valid_out` nor `err_out`.
- R9: `rst` clears both outputs to zero and clears `valid_out` and `err_out`. The first half after reset is only partly seen, so it is never output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock |
| ws_in | input | 1 | Word select (low = left) |
| sd_in | input | 1 | Serial data |
| pin_mode | input | 1 | High: framing taken from `pin_fmt` |
| pin_fmt | input | 2 | Pin-mode framing code |
| fmt_sel | input | 3 | Register-mode framing code |
| left_out | output | 20 | Left sample of the last good frame |
| right_out | output | 20 | Right sample of the last good frame |
| valid_out | output | 1 | One-cycle pulse when a new pair is presented |
| err_out | output | 1 | One-cycle pulse for a half too short for its LSB-justified length |

## Verification
I2S and MSB-justified streams are sent with ones placed beyond the 20th slot. Those ones tell a receiver that ignores them apart from one that counts the slot offset wrong by one. A 16-bit I2S stream shows the zero padding. LSB-justified streams carry negative and positive values with ones in the leading filler slots, so sign extension is distinguished from simply copying the history register. An 18-slot half at 18 bits tests the exact boundary, while 16-slot halves at 20 bits must give an error and no output. Pin mode is driven with a conflicting `fmt_sel`, and unused codes are shown to stay silent.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    localparam int SAMPLE_W = 20;
    localparam int SLOT_W   = 6;

    typedef enum logic [2:0] {
        FMT_I2S   = 3'd0,
        FMT_LSB16 = 3'd1,
        FMT_LSB18 = 3'd2,
        FMT_LSB20 = 3'd3,
        FMT_MSBJ  = 3'd4,
        FMT_NONE  = 3'd7
    } fmt_e;

    typedef struct packed {
        logic ws;
        logic sd;
    } slot_t;

    typedef struct packed {
        logic              stb;
        logic              chg;
        logic              closes;
        logic              side;
        logic [SLOT_W-1:0] idx;
        logic [SLOT_W-1:0] run;
    } pos_t;

    function automatic fmt_e pick_fmt(input logic use_pins, input logic [1:0] pins,
                                      input logic [2:0] code);
        fmt_e f;
        if (use_pins) begin
            case (pins)
                2'b00:   f = FMT_I2S;
                2'b01:   f = FMT_LSB16;
                2'b10:   f = FMT_LSB18;
                default: f = FMT_LSB20;
            endcase
        end else begin
            case (code)
                3'b000:  f = FMT_I2S;
                3'b001:  f = FMT_LSB16;
                3'b010:  f = FMT_LSB18;
                3'b011:  f = FMT_LSB20;
                3'b100:  f = FMT_MSBJ;
                default: f = FMT_NONE;
            endcase
        end
        return f;
    endfunction

    function automatic logic [SLOT_W-1:0] tail_len(input fmt_e f);
        case (f)
            FMT_LSB16: return SLOT_W'(16);
            FMT_LSB18: return SLOT_W'(18);
            FMT_LSB20: return SLOT_W'(20);
            default:   return '0;
        endcase
    endfunction

    function automatic logic [SAMPLE_W-1:0] widen(input logic [SAMPLE_W-1:0] raw,
                                                  input logic [SLOT_W-1:0] n);
        logic [SAMPLE_W-1:0] r;
        logic                s;
        s = (n == '0) ? 1'b0 : raw[n - SLOT_W'(1)];
        for (int i = 0; i < SAMPLE_W; i++) begin
            r[i] = (SLOT_W'(i) < n) ? raw[i] : s;
        end
        return r;
    endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync
    import sarx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  bclk,
    input  logic  ws,
    input  logic  sd,
    output logic  slot_stb,
    output slot_t slot
);
    logic [2:0] chain [STAGES];
    logic       bclk_last;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= {bclk, ws, sd};
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= '0;
            else     chain[g] <= chain[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_last <= 1'b0;
            slot_stb  <= 1'b0;
            slot      <= '0;
        end else begin
            bclk_last <= chain[STAGES-1][2];
            slot_stb  <= chain[STAGES-1][2] & ~bclk_last;
            slot      <= '{ws: chain[STAGES-1][1], sd: chain[STAGES-1][0]};
        end
    end

    // R3: one strobe per rising bit-clock edge, never back to back
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        slot_stb |=> !slot_stb);
endmodule

// File: rtl/sarx_tracker.sv
module sarx_tracker
    import sarx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  slot_stb,
    input  slot_t slot,
    output pos_t  pos
);
    localparam logic [SLOT_W-1:0] CNT_MAX = '1;

    logic              started;
    logic              seen;
    logic              ws_q;
    logic [SLOT_W-1:0] cnt;
    logic              chg;

    assign chg = slot_stb & started & (slot.ws != ws_q);

    always_comb begin
        pos.stb    = slot_stb;
        pos.chg    = chg;
        pos.closes = chg & seen;
        pos.side   = ws_q;
        pos.idx    = chg ? '0 : cnt;
        pos.run    = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            started <= 1'b0;
            seen    <= 1'b0;
            ws_q    <= 1'b0;
            cnt     <= '0;
        end else if (slot_stb) begin
            started <= 1'b1;
            ws_q    <= slot.ws;
            if (chg) seen <= 1'b1;
            if (chg || !started)    cnt <= SLOT_W'(1);
            else if (cnt != CNT_MAX) cnt <= cnt + SLOT_W'(1);
        end
    end
endmodule

// File: rtl/sarx_capture.sv
module sarx_capture
    import sarx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  fmt_e                fmt,
    input  pos_t                pos,
    input  logic                sd,
    output logic                half_done,
    output logic                half_side,
    output logic                half_err,
    output logic [SAMPLE_W-1:0] half_word
);
    logic [SAMPLE_W-1:0] word_q;
    logic [SAMPLE_W-1:0] hist_q;
    logic [SAMPLE_W-1:0] word_next;
    logic [SLOT_W-1:0]   off;
    logic [SLOT_W-1:0]   bitpos;
    logic                lead_fmt;
    logic                tail_fmt;
    logic                hit;
    logic [SLOT_W-1:0]   need;

    assign lead_fmt = (fmt == FMT_I2S) || (fmt == FMT_MSBJ);
    assign need     = tail_len(fmt);
    assign tail_fmt = (need != '0);
    assign off      = (fmt == FMT_I2S) ? SLOT_W'(1) : SLOT_W'(0);
    assign bitpos   = pos.idx - off;
    assign hit      = lead_fmt && (pos.idx >= off) && (bitpos < SLOT_W'(SAMPLE_W));

    always_comb begin
        word_next = pos.chg ? '0 : word_q;
        if (hit) begin
            word_next = word_next |
                ({{(SAMPLE_W-1){1'b0}}, sd} << (SLOT_W'(SAMPLE_W - 1) - bitpos));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q    <= '0;
            hist_q    <= '0;
            half_done <= 1'b0;
            half_side <= 1'b0;
            half_err  <= 1'b0;
            half_word <= '0;
        end else begin
            half_done <= 1'b0;
            half_err  <= 1'b0;
            if (pos.stb) begin
                word_q <= word_next;
                hist_q <= {hist_q[SAMPLE_W-2:0], sd};
            end
            if (pos.closes && fmt != FMT_NONE) begin
                half_done <= 1'b1;
                half_side <= pos.side;
                half_err  <= tail_fmt && (pos.run < need);
                half_word <= tail_fmt ? widen(hist_q, need) : word_q;
            end
        end
    end

    // R7: a short-half error is always tied to a closed half
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
        half_err |-> half_done);
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_in,
    input  logic                ws_in,
    input  logic                sd_in,
    input  logic                pin_mode,
    input  logic [1:0]          pin_fmt,
    input  logic [2:0]          fmt_sel,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                valid_out,
    output logic                err_out
);
    fmt_e                fmt;
    fmt_e                out_tag;
    logic                slot_stb;
    slot_t               slot;
    pos_t                pos;
    logic                half_done;
    logic                half_side;
    logic                half_err;
    logic [SAMPLE_W-1:0] half_word;
    logic [SAMPLE_W-1:0] left_hold;
    logic                left_ok;

    assign fmt = pick_fmt(pin_mode, pin_fmt, fmt_sel);

    sarx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .bclk(bclk_in), .ws(ws_in), .sd(sd_in),
        .slot_stb(slot_stb), .slot(slot)
    );

    sarx_tracker u_track (
        .clk(clk), .rst(rst), .slot_stb(slot_stb), .slot(slot), .pos(pos)
    );

    sarx_capture u_cap (
        .clk(clk), .rst(rst), .fmt(fmt), .pos(pos), .sd(slot.sd),
        .half_done(half_done), .half_side(half_side), .half_err(half_err),
        .half_word(half_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold <= '0;
            left_ok   <= 1'b0;
            left_out  <= '0;
            right_out <= '0;
            valid_out <= 1'b0;
            err_out   <= 1'b0;
            out_tag   <= FMT_NONE;
        end else begin
            valid_out <= 1'b0;
            err_out   <= half_done & half_err;
            if (half_done) begin
                if (!half_side) begin
                    left_hold <= half_word;
                    left_ok   <= !half_err;
                end else begin
                    left_ok <= 1'b0;
                    if (left_ok && !half_err) begin
                        left_out  <= left_hold;
                        right_out <= half_word;
                        valid_out <= 1'b1;
                        out_tag   <= fmt;
                    end
                end
            end
        end
    end

    // R6: valid is a single-cycle pulse
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_out |=> !valid_out);
    // R6: outputs only move together with valid
    a_r6_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid_out |-> ($stable(left_out) && $stable(right_out)));
    // R7: a rejected frame never reports valid in the same cycle
    a_r7_err_excl: assert property (@(posedge clk) disable iff (rst)
        err_out |-> !valid_out);
    // R5: 16-bit LSB-justified samples carry sign copies above bit 15
    a_r5_sext16: assert property (@(posedge clk) disable iff (rst)
        (valid_out && out_tag == FMT_LSB16) |->
        ((left_out[19:15] == 5'h00 || left_out[19:15] == 5'h1F) &&
         (right_out[19:15] == 5'h00 || right_out[19:15] == 5'h1F)));
endmodule

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk_in = 1'b0;
    logic        ws_in = 1'b0;
    logic        sd_in = 1'b0;
    logic        pin_mode = 1'b0;
    logic [1:0]  pin_fmt = 2'b00;
    logic [2:0]  fmt_sel = 3'b000;
    logic [19:0] left_out;
    logic [19:0] right_out;
    logic        valid_out;
    logic        err_out;

    int total = 0;
    int bad = 0;
    int cap_n = 0;
    int err_n = 0;
    logic [19:0] cap_l [8];
    logic [19:0] cap_r [8];
    bit done = 1'b0;

    localparam int M_I2S = 0;
    localparam int M_MSB = 1;
    localparam int M_LSB = 2;

    always #10 clk = ~clk;

    serial_audio_rx dut (
        .clk(clk), .rst(rst), .bclk_in(bclk_in), .ws_in(ws_in), .sd_in(sd_in),
        .pin_mode(pin_mode), .pin_fmt(pin_fmt), .fmt_sel(fmt_sel),
        .left_out(left_out), .right_out(right_out),
        .valid_out(valid_out), .err_out(err_out)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (valid_out) begin
                if (cap_n < 8) begin
                    cap_l[cap_n] = left_out;
                    cap_r[cap_n] = right_out;
                end
                cap_n++;
            end
            if (err_out) err_n++;
        end
    end

    task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] ext(input logic [19:0] v, input int len);
        logic [19:0] r;
        for (int i = 0; i < 20; i++) r[i] = (i < len) ? v[i] : v[len-1];
        return r;
    endfunction

    function automatic logic [19:0] expect_word(input int mode, input int len,
                                                input logic [19:0] v);
        logic [19:0] m;
        if (mode == M_LSB) return ext(v, len);
        m = 20'hFFFFF << (20 - len);
        return v & m;
    endfunction

    function automatic logic gen_bit(input int mode, input int len, input int k,
                                     input int s, input logic [19:0] v);
        int p;
        if (mode == M_LSB) begin
            if (k >= s - len) return v[len - 1 - (k - (s - len))];
            return 1'b1;
        end
        p = (mode == M_I2S) ? k - 1 : k;
        if (p >= 20) return 1'b1;
        if (p >= 0 && p < len) return v[19 - p];
        return 1'b0;
    endfunction

    task automatic slot(input logic w, input logic d);
        #1;
        bclk_in = 1'b0;
        ws_in   = w;
        sd_in   = d;
        repeat (4) @(posedge clk);
        #1;
        bclk_in = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic half(input int mode, input int len, input int s, input logic w,
                        input logic [19:0] v);
        for (int k = 0; k < s; k++) slot(w, gen_bit(mode, len, k, s, v));
    endtask

    task automatic restart();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        cap_n = 0;
        err_n = 0;
    endtask

    task automatic stream(input int mode, input int len, input int s,
                          input logic [19:0] l0, input logic [19:0] r0,
                          input logic [19:0] l1, input logic [19:0] r1);
        restart();
        half(mode, len, s, 1'b1, 20'h5A5A5);
        half(mode, len, s, 1'b0, l0);
        half(mode, len, s, 1'b1, r0);
        half(mode, len, s, 1'b0, l1);
        half(mode, len, s, 1'b1, r1);
        half(mode, len, s, 1'b0, 20'h00000);
        repeat (20) @(posedge clk);
    endtask

    task automatic run_pairs(input string req, input int mode, input int len, input int s,
                             input logic [19:0] l0, input logic [19:0] r0,
                             input logic [19:0] l1, input logic [19:0] r1);
        stream(mode, len, s, l0, r0, l1, r1);
        chk({req, " frame count"}, 20'(cap_n), 20'd2);
        chk({req, " no error"}, 20'(err_n), 20'd0);
        chk({req, " left0"},  cap_l[0], expect_word(mode, len, l0));
        chk({req, " right0"}, cap_r[0], expect_word(mode, len, r0));
        chk({req, " left1"},  cap_l[1], expect_word(mode, len, l1));
        chk({req, " right1"}, cap_r[1], expect_word(mode, len, r1));
    endtask

    task automatic t_reset();
        restart();
        @(negedge clk);
        chk("R9 reset left", left_out, 20'h0);
        chk("R9 reset right", right_out, 20'h0);
        chk("R9 reset valid", {19'h0, valid_out}, 20'h0);
        chk("R9 reset err", {19'h0, err_out}, 20'h0);
    endtask

    task automatic t_i2s20();
        pin_mode = 0; fmt_sel = 3'b000;
        run_pairs("R1 R3 R4 R6 i2s20", M_I2S, 20, 32,
                  20'hA5C3E, 20'h1F0F1, 20'h80001, 20'h7FFFE);
    endtask

    task automatic t_i2s16();
        pin_mode = 0; fmt_sel = 3'b000;
        run_pairs("R4 i2s16 pad", M_I2S, 16, 32,
                  20'hBEEF0, 20'h12340, 20'hFFFF0, 20'h00010);
    endtask

    task automatic t_msb20();
        pin_mode = 0; fmt_sel = 3'b100;
        run_pairs("R1 R4 msbj20", M_MSB, 20, 24,
                  20'hC0FFE, 20'h3A5A1, 20'h00001, 20'h80000);
    endtask

    task automatic t_lsb16();
        pin_mode = 0; fmt_sel = 3'b001;
        run_pairs("R1 R5 lsb16", M_LSB, 16, 32,
                  20'h08001, 20'h01234, 20'h0FFFF, 20'h07FFF);
    endtask

    task automatic t_pin_lsb18_edge();
        pin_mode = 1; pin_fmt = 2'b10; fmt_sel = 3'b100;
        run_pairs("R2 R5 R7 pin lsb18 exact", M_LSB, 18, 18,
                  20'h20001, 20'h1ABCD, 20'h3FFFF, 20'h00002);
    endtask

    task automatic t_pin_lsb20();
        pin_mode = 1; pin_fmt = 2'b11; fmt_sel = 3'b000;
        run_pairs("R2 R5 pin lsb20", M_LSB, 20, 32,
                  20'h80000, 20'h12345, 20'hFFFFF, 20'h6789A);
    endtask

    task automatic t_pin_i2s();
        pin_mode = 1; pin_fmt = 2'b00; fmt_sel = 3'b011;
        run_pairs("R2 pin i2s", M_I2S, 20, 32,
                  20'h13579, 20'h2468A, 20'hFEDCB, 20'h00F00);
    endtask

    task automatic t_short();
        pin_mode = 0; fmt_sel = 3'b011;
        stream(M_LSB, 20, 16, 20'h12345, 20'h54321, 20'h0F0F0, 20'hF0F0F);
        chk("R7 short no frame", 20'(cap_n), 20'd0);
        chk("R7 short error seen", 20'(err_n > 0), 20'd1);
        chk("R7 short left kept", left_out, 20'h0);
        chk("R7 short right kept", right_out, 20'h0);
    endtask

    task automatic t_unused();
        pin_mode = 0; fmt_sel = 3'b101;
        stream(M_I2S, 20, 32, 20'h11111, 20'h22222, 20'h33333, 20'h44444);
        chk("R8 code 101 no frame", 20'(cap_n), 20'd0);
        chk("R8 code 101 no error", 20'(err_n), 20'd0);
        fmt_sel = 3'b111;
        stream(M_LSB, 20, 16, 20'h11111, 20'h22222, 20'h33333, 20'h44444);
        chk("R8 code 111 no frame", 20'(cap_n), 20'd0);
        chk("R8 code 111 no error", 20'(err_n), 20'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_i2s20();
        t_i2s16();
        t_msb20();
        t_lsb16();
        t_pin_lsb18_edge();
        t_pin_lsb20();
        t_pin_i2s();
        t_short();
        t_unused();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule